// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers fifteen interrupt lines, numbered 1 to 15, and turns them into one request towards the CPU. The request comes with the number of the source to serve.

- **Latching.** Each line is latched into a pending register. A per-line mode bit chooses whether a rising edge or a high level sets the pending bit.
- **Masking.** A per-line enable mask decides which pending sources may raise the request. Masked sources still record their events.
- **Priority.** A per-line level bit puts each source in the high or the low group. Any enabled high-group source is served before every low-group one. Inside a group, the larger source number wins.
- **Acknowledge.** When the CPU pulses the acknowledge input, the pending bit of the source shown at that moment is cleared.
- **Software access.** A force register lets software inject events, and a write-one-to-clear pending register lets software drop them.

A secondary controller can be chained in; it is enabled by a parameter and is on by default. It holds 32 more inputs, each with its own edge-latched pending bit and enable bit.

- **Summary line.** The OR of its enabled pending bits appears as primary source 14.
- **Status.** A status register gives the number of its highest-numbered enabled pending input and a valid flag.
- **Acknowledge.** Acknowledging source 14 clears the secondary pending bit that the status register names.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, irq_o is 0 and irq_id_o is 0. The level, mask, mode, pending, secondary pending and secondary mask registers all read 0.
- R2: Register map: 0 = level, 1 = mask, 2 = pending, 3 = force (write only), 4 = mode, 5 = secondary pending, 6 = secondary mask, 7 = secondary status, 8 = secondary force (write only). In the primary registers, bit k belongs to source k (k = 1..15), and src_i[k-1] drives source k. When mode bit k is 1, a rising edge on the line sets pending bit k. When it is 0, the pending bit is set in every cycle the line is high, so it returns after an acknowledge while the line stays high.
- R3: Pending bits are recorded whatever the mask says. Only sources whose mask bit is 1 can raise irq_o. A pending masked source leaves irq_o at 0 and becomes the request as soon as it is unmasked.
- R4: When a source's level bit is 1, it is in the high group. Any enabled pending high-group source is presented ahead of every low-group source, whatever the numbers.
- R5: Within one group, the enabled pending source with the highest number is presented.
- R6: irq_o is 1 exactly when some enabled source is pending, and irq_id_o then gives its number (1..15). irq_id_o is 0 whenever irq_o is 0.
- R7: An ack_i pulse while irq_o is 1 clears the pending bit of the source given by irq_id_o in that cycle. A set arriving in that same cycle for that same source wins, and the bit stays pending. An ack_i while irq_o is 0 changes no pending bit.
- R8: Writing 1s to the force register sets those pending bits. Writing 1s to the pending register clears those bits.
- R9: The secondary pending bit j is set by a rising edge on ext_i[j] or by a 1 written to bit j of the secondary force register. It is cleared by a 1 written to bit j of the secondary pending register. Primary source 14 reads as pending exactly while some secondary input is both pending and enabled in the secondary mask. src_i[13] is ignored.
- R10: Secondary status: bit 5 = valid, and bits 4:0 give the highest-numbered secondary input that is pending and enabled. The register reads 0 when no such input exists.
- R11: An ack_i while irq_id_o is 14 clears the secondary pending bit named by the status register. Primary source 14 stays requested while other enabled secondary inputs remain pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 15 | Primary interrupt lines; bit k-1 is source k |
| ext_i | input | 32 | Secondary controller interrupt lines |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational from addr_i) |
| ack_i | input | 1 | CPU acknowledge of the presented source |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_id_o | output | 4 | Number of the presented source, 0 when idle |

## Verification
The acknowledge that clears a pending bit and a new event that sets the same bit can fall in the same clock edge. The bench provokes this twice:

- **Edge case.** The acknowledge pulse is driven together with a rising edge on the source being served.
- **Level case.** The acknowledge is driven while a level-mode line is still held high.

Both times it judges the result by checking that irq_o and irq_id_o still present that source one cycle later. It then drops the line and acknowledges once more, and checks that the request goes idle, which shows that the acknowledge itself was honoured.

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NSRC     = 15,
  parameter int NEXT     = 32,
  parameter int EXT_EN   = 1,
  parameter int EXT_LINE = 14,
  parameter int DW       = 32,
  parameter int AW       = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NEXT-1:0] ext_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic            ack_i,
  output logic            irq_o,
  output logic [$clog2(NSRC+1)-1:0] irq_id_o
);
  localparam int IDW = $clog2(NSRC+1);
  localparam int EXW = $clog2(NEXT);
  localparam logic [AW-1:0] A_LVL = AW'(0), A_MSK = AW'(1), A_PEND = AW'(2),
                            A_FORCE = AW'(3), A_MODE = AW'(4), A_XPEND = AW'(5),
                            A_XMSK = AW'(6), A_XSTAT = AW'(7), A_XFORCE = AW'(8);

  logic [NSRC:0] lvl_q, msk_q, mode_q, pend_q, src_q;
  logic [NSRC:0] line, rise, hw_set, sw_set, sw_clr, ack_clr, set_all, eff, req, hi, lo;
  logic [IDW-1:0] id_hi, id_lo;
  logic           ext_sum, ext_vld;
  logic [NEXT-1:0] ext_pend, ext_msk;
  logic [EXW-1:0] ext_idx;
  logic           do_ack;

  assign line    = {src_i, 1'b0};
  assign rise    = line & ~src_q;
  assign hw_set  = (mode_q & rise) | (~mode_q & line);
  assign sw_set  = (wr_i && addr_i == A_FORCE) ? {wdata_i[NSRC:1], 1'b0} : '0;
  assign sw_clr  = (wr_i && addr_i == A_PEND)  ? {wdata_i[NSRC:1], 1'b0} : '0;
  assign do_ack  = ack_i && irq_o;
  assign ack_clr = do_ack ? ((NSRC+1)'(1) << irq_id_o) : '0;
  assign set_all = hw_set | sw_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      msk_q  <= '0;
      mode_q <= '0;
      pend_q <= '0;
      src_q  <= '0;
    end else begin
      src_q  <= line;
      pend_q <= (pend_q & ~(sw_clr | ack_clr)) | set_all;
      if (wr_i && addr_i == A_LVL)  lvl_q  <= {wdata_i[NSRC:1], 1'b0};
      if (wr_i && addr_i == A_MSK)  msk_q  <= {wdata_i[NSRC:1], 1'b0};
      if (wr_i && addr_i == A_MODE) mode_q <= {wdata_i[NSRC:1], 1'b0};
    end
  end

  always_comb begin
    eff = pend_q;
    if (EXT_EN != 0) eff[EXT_LINE] = ext_sum;
  end

  assign req = eff & msk_q;
  assign hi  = req & lvl_q;
  assign lo  = req & ~lvl_q;

  always_comb begin
    id_hi = '0;
    id_lo = '0;
    for (int i = 1; i <= NSRC; i++) begin
      if (hi[i]) id_hi = IDW'(i);
      if (lo[i]) id_lo = IDW'(i);
    end
  end

  assign irq_o    = |req;
  assign irq_id_o = (|hi) ? id_hi : id_lo;

  generate
    if (EXT_EN != 0) begin : g_ext
      logic [NEXT-1:0] xpend_q, xmsk_q, xin_q, xreq, xset, xclr;
      logic [EXW-1:0]  xidx;

      assign xreq = xpend_q & xmsk_q;
      always_comb begin
        xidx = '0;
        for (int j = 0; j < NEXT; j++)
          if (xreq[j]) xidx = EXW'(j);
      end
      assign xset = (ext_i & ~xin_q) |
                    ((wr_i && addr_i == A_XFORCE) ? wdata_i[NEXT-1:0] : '0);
      assign xclr = ((wr_i && addr_i == A_XPEND) ? wdata_i[NEXT-1:0] : '0) |
                    ((do_ack && irq_id_o == IDW'(EXT_LINE)) ? (NEXT'(1) << xidx) : '0);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          xpend_q <= '0;
          xmsk_q  <= '0;
          xin_q   <= '0;
        end else begin
          xin_q   <= ext_i;
          xpend_q <= (xpend_q & ~xclr) | xset;
          if (wr_i && addr_i == A_XMSK) xmsk_q <= wdata_i[NEXT-1:0];
        end
      end

      assign ext_sum  = |xreq;
      assign ext_vld  = |xreq;
      assign ext_idx  = xidx;
      assign ext_pend = xpend_q;
      assign ext_msk  = xmsk_q;

      p_ext_stat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|xreq) |-> ((xreq >> xidx) == NEXT'(1)));
      p_ext_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ack && irq_id_o == IDW'(EXT_LINE) && !xset[xidx]) |=> !xpend_q[$past(xidx)]);
    end else begin : g_noext
      assign ext_sum  = 1'b0;
      assign ext_vld  = 1'b0;
      assign ext_idx  = '0;
      assign ext_pend = '0;
      assign ext_msk  = '0;
    end
  endgenerate

  always_comb begin
    case (addr_i)
      A_LVL:   rdata_o = DW'(lvl_q);
      A_MSK:   rdata_o = DW'(msk_q);
      A_PEND:  rdata_o = DW'(eff);
      A_MODE:  rdata_o = DW'(mode_q);
      A_XPEND: rdata_o = DW'(ext_pend);
      A_XMSK:  rdata_o = DW'(ext_msk);
      A_XSTAT: rdata_o = DW'({ext_vld, ext_idx});
      default: rdata_o = '0;
    endcase
  end

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (irq_id_o == '0));
  p_req_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (eff[irq_id_o] && msk_q[irq_id_o]));
  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((eff & msk_q) == '0) |-> !irq_o);
  p_hi_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !lvl_q[irq_id_o]) |-> ((eff & msk_q & lvl_q) == '0));
  p_top_number_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (((eff & msk_q & (lvl_q[irq_id_o] ? lvl_q : ~lvl_q)) >> irq_id_o) == (NSRC+1)'(1)));
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_all != '0) |=> ((pend_q & $past(set_all)) == $past(set_all)));
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ack && (EXT_EN == 0 || irq_id_o != IDW'(EXT_LINE)) && !set_all[irq_id_o])
      |=> !pend_q[$past(irq_id_o)]);
endmodule

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] src_i = '0;
  logic [31:0] ext_i = '0;
  logic        wr_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        ack_i = 1'b0;
  logic        irq_o;
  logic [3:0]  irq_id_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .src_i(src_i), .ext_i(ext_i), .wr_i(wr_i),
               .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_i(ack_i),
               .irq_o(irq_o), .irq_id_o(irq_id_o));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    tick();
    wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic ack();
    ack_i = 1'b1;
    tick();
    ack_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 id", 32'(irq_id_o), 0);
    for (int a = 0; a < 7; a++) begin
      if (a == 3) continue;
      rd(4'(a), d);
      chk($sformatf("R1 reg%0d", a), d, 0);
    end
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(4, 32'hFFFE);
    wr(1, 32'h0008);
    src_i[2] = 1'b1;
    tick();
    chk("R2 edge latch id", {irq_o, 27'd0, irq_id_o}, {1'b1, 27'd0, 4'd3});
    ack();
    chk("R2 edge no relatch", 32'(irq_o), 0);
    rd(2, d);
    chk("R2 edge pend", d, 0);
    src_i[2] = 1'b0;
    tick();
  endtask

  task automatic t_level();
    wr(4, 32'hFFDE);
    wr(1, 32'h0020);
    src_i[4] = 1'b1;
    tick();
    chk("R2 level id", 32'(irq_id_o), 5);
    ack();
    chk("R2 R7 level held after ack", {irq_o, 27'd0, irq_id_o}, {1'b1, 27'd0, 4'd5});
    src_i[4] = 1'b0;
    ack();
    chk("R2 level dropped", 32'(irq_o), 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(1, 32'h0);
    src_i[6] = 1'b1; tick();
    src_i[6] = 1'b0; tick();
    chk("R3 masked quiet", 32'(irq_o), 0);
    rd(2, d);
    chk("R3 masked recorded", d, 32'h80);
    wr(1, 32'h80);
    chk("R3 unmask id", {irq_o, 27'd0, irq_id_o}, {1'b1, 27'd0, 4'd7});
    wr(2, 32'h80);
    chk("R8 w1c irq", 32'(irq_o), 0);
    rd(2, d);
    chk("R8 w1c pend", d, 0);
  endtask

  task automatic t_order();
    wr(0, 32'h0);
    wr(1, 32'hFFFE);
    wr(3, 32'h1204);
    chk("R5 R8 top number", 32'(irq_id_o), 12);
    ack();
    chk("R5 R7 next", 32'(irq_id_o), 9);
    ack();
    chk("R5 last", 32'(irq_id_o), 2);
    ack();
    chk("R6 idle", {irq_o, 27'd0, irq_id_o}, 0);
  endtask

  task automatic t_levels();
    wr(0, 32'h0008);
    wr(3, 32'h2008);
    chk("R4 high group first", 32'(irq_id_o), 3);
    ack();
    chk("R4 low after", 32'(irq_id_o), 13);
    ack();
    chk("R4 idle", 32'(irq_o), 0);
    wr(0, 32'h0);
  endtask

  task automatic t_conflict();
    logic [31:0] d;
    wr(3, 32'h40);
    chk("R7 presented", 32'(irq_id_o), 6);
    src_i[5] = 1'b1;
    ack();
    chk("R7 set wins", {irq_o, 27'd0, irq_id_o}, {1'b1, 27'd0, 4'd6});
    src_i[5] = 1'b0;
    ack();
    chk("R7 cleared", 32'(irq_o), 0);
    wr(1, 32'h0);
    wr(3, 32'h100);
    ack();
    rd(2, d);
    chk("R7 idle ack ignored", d, 32'h100);
    wr(2, 32'h100);
  endtask

  task automatic t_ext();
    logic [31:0] d;
    wr(1, 32'h4000);
    wr(6, 32'h0010_0008);
    ext_i[3] = 1'b1; ext_i[20] = 1'b1;
    tick();
    ext_i = '0;
    chk("R9 summary id", {irq_o, 27'd0, irq_id_o}, {1'b1, 27'd0, 4'd14});
    rd(7, d);
    chk("R10 status", d, 32'h34);
    rd(5, d);
    chk("R9 ext pend", d, 32'h0010_0008);
    rd(2, d);
    chk("R9 line14 pend", d, 32'h4000);
    ack();
    rd(7, d);
    chk("R11 status after ack", d, 32'h23);
    chk("R11 still requested", {irq_o, 27'd0, irq_id_o}, {1'b1, 27'd0, 4'd14});
    ack();
    chk("R11 idle", 32'(irq_o), 0);
    rd(7, d);
    chk("R10 status empty", d, 0);
    wr(8, 32'h8000_0000);
    rd(5, d);
    chk("R9 ext force", d, 32'h8000_0000);
    rd(7, d);
    chk("R10 masked ext", d, 0);
    chk("R9 masked ext quiet", 32'(irq_o), 0);
    wr(5, 32'h8000_0000);
    rd(5, d);
    chk("R9 ext w1c", d, 0);
    src_i[13] = 1'b1; tick();
    src_i[13] = 1'b0; tick();
    chk("R9 src14 ignored", 32'(irq_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_edge();
    t_level();
    t_mask();
    t_order();
    t_levels();
    t_conflict();
    t_ext();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule